// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two expiry stages, driven through a small register port. A prescaler divides the system clock into a fixed tick. With the default divisor and a 50 MHz clock, one tick lasts 0.6 s, so a timeout of N seconds is programmed as N*10/6 ticks. A down-counter is loaded from a programmed timer value and loses one count per tick. When it expires it raises a sticky timeout flag and reloads itself. If software has not cleared that flag before the next expiry, the block raises a second-stage flag and a boot flag. At that second expiry it also emits a one-cycle system-action pulse, unless the no-reboot strap is high.

Software reaches the register space through a request channel that uses valid/ready. The request ready is always high, so a request is accepted in the cycle its valid is high and never waits. Every accepted read returns exactly one response one cycle later. The response side has no ready and cannot be stalled, so the requester must always be able to take it. Writes give no response. An access covers one, two or four consecutive byte offsets, little-endian. This lets paired registers be read together in one wider access.

Register offsets (byte addresses): 0x00–0x01 reload/live count, 0x02 data-in, 0x03 data-out, 0x04–0x05 primary status, 0x06–0x07 secondary status, 0x08–0x09 primary control, 0x0A–0x0B secondary control, 0x0C message A, 0x0D message B, 0x0E watchdog-count byte, 0x10 software-interrupt byte, 0x12–0x13 timer value. All other offsets read zero and ignore writes.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, reads return: timer value 0x0004, secondary control 0x0008, software-interrupt byte 0x03, and zero for every other register, including the live count.
- R2: The timer value keeps only its low 10 bits. Writing 0xFFFF reads back as 0x03FF.
- R3: Any write that touches offset 0x00 or 0x01 loads the counter from the timer value and restarts the prescaler phase. A read of offsets 0x00–0x01 returns the live count.
- R4: The count drops by exactly one on every tick. The first tick comes TICK_DIV clock cycles after the load, and later ticks follow every TICK_DIV cycles.
- R5: A tick seen while the count is 1 is an expiry. The counter reloads from the timer value. If bit 3 (timeout, 0x0008) of the primary status register is clear, it sets. For a timer value of 0x3FF, the count reads 1 after 1022 ticks and the timeout bit sets on tick 1023.
- R6: An expiry that occurs while the timeout bit is already set sets bit 1 (second stage, 0x0002) and bit 2 (boot, 0x0004) of the secondary status register.
- R7: At a second-stage expiry, sys_action pulses high for exactly one cycle, one cycle after the expiry, and only when no_reboot is low.
- R8: All status bits clear only when a one is written to them. Writing zeros leaves them unchanged. A hardware set in the same cycle as a clear wins.
- R9: A write to data-in (0x02) or data-out (0x03) stores the byte and sets bits 1 and 2 (0x0006) of the primary status register.
- R10: While bit 11 (0x0800) of the primary control register is set, the count does not change on ticks. A load still takes effect.
- R11: req_size 0 accesses one byte, 1 accesses two bytes and 2 or 3 access four bytes. The bytes come from consecutive offsets starting at req_addr, with the lowest offset in the lowest byte. Unused upper response bytes read zero.
- R12: req_ready is always high. Each accepted read gives rsp_valid for one cycle, exactly one cycle later. Writes give no response.
- R13: A count of zero stays at zero and never expires until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| no_reboot | input | 1 | Strap: high suppresses the system-action pulse |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request ready, always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Starting byte offset |
| req_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| req_wdata | input | 32 | Write data, byte i goes to offset req_addr+i |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| sys_action | output | 1 | One-cycle second-stage action pulse |

## Verification
Assertions check on every cycle that the count steps down by one per unhalted tick and holds while halted or at zero. They also check that an expiry reloads from the timer value, that ticks never come back-to-back, that the second-stage flag and the timeout clear only have a legal cause, that sys_action is a single-cycle pulse blocked by the strap, and that each response follows a read. The bench scenarios are what show the exact tick count at which a flag sets, including the 1022/1023 boundary at the largest timer value. The scenarios also cover the reset contents, the paired-register layout seen through byte, word and dword reads, and the end-to-end sequence from a cleared flag through two expiries to the action pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2
  } acc_size_e;

  // byte offsets of the register space
  localparam int OFS_RELOAD = 0;
  localparam int OFS_DIN    = 2;
  localparam int OFS_DOUT   = 3;
  localparam int OFS_STS1   = 4;
  localparam int OFS_STS2   = 6;
  localparam int OFS_CTL1   = 8;
  localparam int OFS_CTL2   = 10;
  localparam int OFS_MSGA   = 12;
  localparam int OFS_MSGB   = 13;
  localparam int OFS_WDC    = 14;
  localparam int OFS_SWIRQ  = 16;
  localparam int OFS_TMR    = 18;

  // status and control bit positions
  localparam int B_SWSMI   = 1;
  localparam int B_INTSTS  = 2;
  localparam int B_TIMEOUT = 3;
  localparam int B_SECOND  = 1;
  localparam int B_BOOT    = 2;
  localparam int B_HALT    = 11;

  localparam logic [15:0] STS1_KEEP  = 16'h000E;
  localparam logic [15:0] STS2_KEEP  = 16'h0006;
  localparam logic [15:0] TMR_RST    = 16'h0004;
  localparam logic [15:0] CTL2_RST   = 16'h0008;
  localparam logic [7:0]  SWIRQ_RST  = 8'h03;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 30_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || restart)      phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R4
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          halt,
  input  logic          load,
  input  logic [CW-1:0] tmr,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic step;
  assign step   = tick && !halt && !load && (cnt != '0);
  assign expire = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (load)    cnt <= tmr;
    else if (expire)  cnt <= tmr;
    else if (step)    cnt <= cnt - 1'b1;
  end

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !halt && !load && cnt > ONE) |=> cnt == CW'($past(cnt) - 1));
  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !load) |=> $stable(cnt));
  // R5
  expire_reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == $past(tmr));
  // R13
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> cnt == '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int AW = 5,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          no_reboot_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic [31:0]   req_wdata_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_data_o,
  input  logic [CW-1:0] cnt_i,
  input  logic          expire_i,
  output logic [CW-1:0] tmr_o,
  output logic          halt_o,
  output logic          load_o,
  output logic          sys_action_o
);
  localparam logic [15:0] TMR_MASK = 16'((32'd1 << CW) - 1);

  logic [7:0]  din_q, dout_q, msga_q, msgb_q, wdc_q, swirq_q;
  logic [7:0]  din_n, dout_n, msga_n, msgb_n, wdc_n, swirq_n;
  logic [15:0] sts1_q, sts2_q, ctl1_q, ctl2_q, tmr_q;
  logic [15:0] sts1_n, sts2_n, ctl1_n, ctl2_n, tmr_n;
  logic        data_hit, wr_fire, rd_fire, action_q;
  logic [AW-1:0] off, roff;
  logic [7:0]  lane;
  logic [31:0] rd_d;
  logic [15:0] cnt16;
  int          n_lanes;

  assign req_ready_o = 1'b1;
  assign wr_fire = req_valid_i && req_write_i;
  assign rd_fire = req_valid_i && !req_write_i;
  assign cnt16   = 16'(cnt_i);

  always_comb begin
    case (req_size_i)
      ACC_BYTE: n_lanes = 1;
      ACC_WORD: n_lanes = 2;
      default:  n_lanes = 4;
    endcase
  end

  // write path: lane decode, then hardware sets take priority
  always_comb begin
    din_n = din_q; dout_n = dout_q; msga_n = msga_q; msgb_n = msgb_q;
    wdc_n = wdc_q; swirq_n = swirq_q; sts1_n = sts1_q; sts2_n = sts2_q;
    ctl1_n = ctl1_q; ctl2_n = ctl2_q; tmr_n = tmr_q;
    load_o = 1'b0; data_hit = 1'b0; off = '0; lane = '0;
    if (wr_fire) begin
      for (int i = 0; i < 4; i++) begin
        if (i < n_lanes) begin
          off  = req_addr_i + AW'(i);
          lane = req_wdata_i[8*i +: 8];
          case (off)
            AW'(OFS_RELOAD), AW'(OFS_RELOAD + 1): load_o = 1'b1;
            AW'(OFS_DIN):      begin din_n  = lane; data_hit = 1'b1; end
            AW'(OFS_DOUT):     begin dout_n = lane; data_hit = 1'b1; end
            AW'(OFS_STS1):     sts1_n[7:0]  = sts1_n[7:0] & ~lane;
            AW'(OFS_STS2):     sts2_n[7:0]  = sts2_n[7:0] & ~lane;
            AW'(OFS_CTL1):     ctl1_n[7:0]  = lane;
            AW'(OFS_CTL1 + 1): ctl1_n[15:8] = lane;
            AW'(OFS_CTL2):     ctl2_n[7:0]  = lane;
            AW'(OFS_CTL2 + 1): ctl2_n[15:8] = lane;
            AW'(OFS_MSGA):     msga_n = lane;
            AW'(OFS_MSGB):     msgb_n = lane;
            AW'(OFS_WDC):      wdc_n  = lane;
            AW'(OFS_SWIRQ):    swirq_n = lane;
            AW'(OFS_TMR):      tmr_n[7:0]  = lane;
            AW'(OFS_TMR + 1):  tmr_n[15:8] = lane;
            default: ;
          endcase
        end
      end
    end
    tmr_n = tmr_n & TMR_MASK;
    if (data_hit) begin
      sts1_n[B_SWSMI]  = 1'b1;
      sts1_n[B_INTSTS] = 1'b1;
    end
    if (expire_i) begin
      if (sts1_q[B_TIMEOUT]) begin
        sts2_n[B_SECOND] = 1'b1;
        sts2_n[B_BOOT]   = 1'b1;
      end else begin
        sts1_n[B_TIMEOUT] = 1'b1;
      end
    end
    sts1_n = sts1_n & STS1_KEEP;
    sts2_n = sts2_n & STS2_KEEP;
  end

  // read path: assemble consecutive bytes little-endian
  always_comb begin
    rd_d = '0; roff = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < n_lanes) begin
        roff = req_addr_i + AW'(i);
        case (roff)
          AW'(OFS_RELOAD):     rd_d[8*i +: 8] = cnt16[7:0];
          AW'(OFS_RELOAD + 1): rd_d[8*i +: 8] = cnt16[15:8];
          AW'(OFS_DIN):        rd_d[8*i +: 8] = din_q;
          AW'(OFS_DOUT):       rd_d[8*i +: 8] = dout_q;
          AW'(OFS_STS1):       rd_d[8*i +: 8] = sts1_q[7:0];
          AW'(OFS_STS1 + 1):   rd_d[8*i +: 8] = sts1_q[15:8];
          AW'(OFS_STS2):       rd_d[8*i +: 8] = sts2_q[7:0];
          AW'(OFS_STS2 + 1):   rd_d[8*i +: 8] = sts2_q[15:8];
          AW'(OFS_CTL1):       rd_d[8*i +: 8] = ctl1_q[7:0];
          AW'(OFS_CTL1 + 1):   rd_d[8*i +: 8] = ctl1_q[15:8];
          AW'(OFS_CTL2):       rd_d[8*i +: 8] = ctl2_q[7:0];
          AW'(OFS_CTL2 + 1):   rd_d[8*i +: 8] = ctl2_q[15:8];
          AW'(OFS_MSGA):       rd_d[8*i +: 8] = msga_q;
          AW'(OFS_MSGB):       rd_d[8*i +: 8] = msgb_q;
          AW'(OFS_WDC):        rd_d[8*i +: 8] = wdc_q;
          AW'(OFS_SWIRQ):      rd_d[8*i +: 8] = swirq_q;
          AW'(OFS_TMR):        rd_d[8*i +: 8] = tmr_q[7:0];
          AW'(OFS_TMR + 1):    rd_d[8*i +: 8] = tmr_q[15:8];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= '0; dout_q <= '0; msga_q <= '0; msgb_q <= '0; wdc_q <= '0;
      swirq_q <= SWIRQ_RST; sts1_q <= '0; sts2_q <= '0; ctl1_q <= '0;
      ctl2_q <= CTL2_RST; tmr_q <= TMR_RST;
      rsp_valid_o <= 1'b0; rsp_data_o <= '0; action_q <= 1'b0;
    end else begin
      din_q <= din_n; dout_q <= dout_n; msga_q <= msga_n; msgb_q <= msgb_n;
      wdc_q <= wdc_n; swirq_q <= swirq_n; sts1_q <= sts1_n; sts2_q <= sts2_n;
      ctl1_q <= ctl1_n; ctl2_q <= ctl2_n; tmr_q <= tmr_n;
      rsp_valid_o <= rd_fire;
      if (rd_fire) rsp_data_o <= rd_d;
      action_q <= expire_i && sts1_q[B_TIMEOUT] && !no_reboot_i;
    end
  end

  assign tmr_o        = tmr_q[CW-1:0];
  assign halt_o       = ctl1_q[B_HALT];
  assign sys_action_o = action_q;

  // R7
  action_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_i && no_reboot_i) |=> !sys_action_o);
  // R7
  action_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sys_action_o |=> !sys_action_o);
  // R6
  second_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts2_q[B_SECOND]) |-> $past(expire_i));
  // R8
  timeout_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sts1_q[B_TIMEOUT]) |-> $past(wr_fire));
  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(rd_fire));
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int TICK_DIV = 30_000_000,
  parameter int TMR_W    = 10,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              no_reboot,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              sys_action
);
  logic             tick, halt, load, expire;
  logic [TMR_W-1:0] cnt, tmr;

  wdog_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst(rst), .restart(load), .tick(tick)
  );

  wdog_counter #(.CW(TMR_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt), .load(load),
    .tmr(tmr), .cnt(cnt), .expire(expire)
  );

  wdog_regs #(.AW(ADDR_W), .CW(TMR_W)) u_regs (
    .clk(clk), .rst(rst), .no_reboot_i(no_reboot),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .cnt_i(cnt), .expire_i(expire), .tmr_o(tmr), .halt_o(halt),
    .load_o(load), .sys_action_o(sys_action)
  );
endmodule

// File: tb/twostage_wdog_test.sv
module twostage_wdog_test;
  localparam int DIV = 8;

  logic        clk = 1'b0, rst = 1'b1, no_reboot = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  wire         req_ready, rsp_valid, sys_action;
  wire [31:0]  rsp_data;

  twostage_wdog #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .no_reboot(no_reboot),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sys_action(sys_action)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0, act_cnt = 0, t_load = 0, act_base = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (sys_action) act_cnt++;
    if (rsp_valid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_data !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int sz, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'(a);
    req_size = 2'(sz); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int a, input int sz, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'(a); req_size = 2'(sz);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reload();
    wr(0, 1, 32'h4);
    t_load = cyc;
  endtask

  // position so that the next read samples mid-way through tick n
  task automatic at_tick(input int n);
    while (cyc < t_load + n * DIV + DIV / 2 - 1) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset contents
    rd(0, 1, 32'h0, "R1 count");
    rd(2, 1, 32'h0, "R1 data pair");
    rd(4, 2, 32'h0, "R1 status pair");
    rd(8, 2, 32'h0008_0000, "R1 control pair");
    rd(12, 1, 32'h0, "R1 messages");
    rd(14, 0, 32'h0, "R1 wdcount");
    rd(16, 0, 32'h3, "R1 swirq");
    rd(18, 1, 32'h4, "R1 timer");
    chk(req_ready === 1'b1, "R12 ready", int'(req_ready), 1);
    // R13: zero count stays idle
    repeat (4 * DIV) @(negedge clk);
    rd(4, 2, 32'h0, "R13 no expiry at zero");
    rd(0, 1, 32'h0, "R13 count zero");

    // R3 R4 R5 R6 R8 basic two-stage run, strap high
    wr(18, 1, 32'h5);
    reload();
    at_tick(0); rd(0, 1, 32'h5, "R3 count after load");
    at_tick(1); rd(0, 1, 32'h4, "R4 one tick");
    at_tick(4); rd(0, 1, 32'h1, "R4 four ticks");
    rd(4, 1, 32'h0, "R5 no timeout before expiry");
    at_tick(5); rd(4, 1, 32'h8, "R5 timeout set");
    rd(0, 1, 32'h5, "R5 auto reload");
    wr(4, 0, 32'h0);
    rd(4, 1, 32'h8, "R8 zero write keeps");
    wr(4, 1, 32'h8);
    rd(4, 1, 32'h0, "R8 timeout cleared");
    at_tick(10); rd(4, 1, 32'h8, "R5 timeout again");
    rd(6, 1, 32'h0, "R6 no second after clear");
    at_tick(15); rd(6, 1, 32'h6, "R6 second and boot");
    chk(act_cnt == 0, "R7 strap blocks action", act_cnt, 0);
    wr(6, 1, 32'h2);
    rd(6, 1, 32'h4, "R8 clear second only");
    wr(6, 1, 32'h4);
    rd(6, 1, 32'h0, "R8 clear boot");

    // R7 action with strap low
    wr(18, 1, 32'h3);
    reload();
    wr(4, 1, 32'hE);
    wr(6, 1, 32'h6);
    act_base = act_cnt;
    no_reboot = 1'b0;
    at_tick(3); rd(4, 1, 32'h8, "R7 first stage");
    chk(act_cnt == act_base, "R7 no action on first", act_cnt - act_base, 0);
    at_tick(6);
    chk(act_cnt - act_base == 1, "R7 single pulse", act_cnt - act_base, 1);
    rd(6, 1, 32'h6, "R7 second flags");
    no_reboot = 1'b1;

    // R2 R5 largest timer value
    wr(18, 1, 32'hFFFF);
    rd(18, 1, 32'h3FF, "R2 masked timer");
    reload();
    wr(4, 1, 32'hE);
    at_tick(1022); rd(0, 1, 32'h1, "R5 count one at 1022");
    rd(4, 1, 32'h0, "R5 no timeout at 1022");
    at_tick(1023); rd(4, 1, 32'h8, "R5 timeout at 1023");
    rd(0, 1, 32'h3FF, "R5 reload max");

    // R10 halt
    wr(8, 1, 32'h0800);
    rd(8, 2, 32'h0008_0800, "R10 R11 control pair");
    wr(18, 1, 32'h5);
    reload();
    at_tick(3); rd(0, 1, 32'h5, "R10 halted count");
    wr(8, 1, 32'h0);
    at_tick(5); rd(0, 1, 32'h3, "R10 resumes");
    wr(8, 1, 32'h0800);

    // R9 data port (halted, no expiries)
    wr(4, 1, 32'hE);
    rd(4, 1, 32'h0, "R9 cleared");
    wr(2, 0, 32'h11);
    rd(4, 1, 32'h6, "R9 data-in sets");
    wr(4, 1, 32'h6);
    rd(4, 1, 32'h0, "R9 W1C");
    wr(3, 0, 32'h22);
    rd(4, 1, 32'h6, "R9 data-out sets");
    rd(2, 1, 32'h2211, "R11 data pair");

    // R11 widths
    wr(12, 0, 32'hA5);
    wr(13, 0, 32'h3C);
    rd(12, 1, 32'h3CA5, "R11 message pair");
    wr(14, 0, 32'h5A);
    rd(14, 0, 32'h5A, "R11 byte read");
    wr(12, 2, 32'h0000_7766);
    rd(12, 2, 32'h0000_7766, "R11 dword write");
    rd(13, 0, 32'h77, "R11 odd byte");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R12 watchdog expired actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule